// File: doc/BRIEF.md
# Serial Isolation Identifier Shifter

During the isolation phase of a plug-and-play card, the host learns the card's identity by reading one isolation register over and over. This block holds that conversation from the card's side. It takes a 64-bit identifier (vendor code plus device and serial fields) and sends it one bit at a time, least significant bit first. An 8-bit checksum follows, and it is sent least significant bit first as well.

Each bit takes two consecutive reads. The first read returns 0x55 for a one and 0x00 for a zero. The second read returns that value shifted left by one, so a one gives 0xAA and a zero gives 0x00.

The checksum is a shift register. A wake command seeds it, and it is updated as each identifier bit is sent. When the whole 72-bit stream has been read, the block leaves isolation and pulses a done strobe, which tells the surrounding logic to move the card into its configuration phase. The finished checksum is also presented on an output once the last identifier bit has gone out.

Top module: `iso_id_shifter`

## Requirements
- R1: After reset, iso_active, iso_done and csum_valid are 0 and rd_data is 0x00.
- R2: A wake pulse sets iso_active, loads the checksum register with 0x6A, clears csum_valid and restarts the stream at bit 0 on the first read of a pair. This holds even when a wake arrives in the middle of a sequence.
- R3: A read in isolation that opens a pair returns 0x55 in rd_data on the following cycle if the current bit is 1, and 0x00 if it is 0.
- R4: The read that closes a pair returns the previous rd_data shifted left by one bit (0xAA or 0x00).
- R5: Stream order is identifier bit 0 up to bit 63, then checksum bit 0 up to bit 7, one bit per pair.
- R6: For each identifier bit b that is sent, the checksum register shifts right by one, and its new bit 7 becomes old bit 0 XOR old bit 1 XOR b. The checksum bits that are sent are the register value after all 64 updates.
- R7: On the read that closes the 72nd pair, iso_active drops and iso_done is high for exactly one cycle. iso_done is 0 at every other time.
- R8: A read while iso_active is 0 returns 0x00 and does not start or advance the stream.
- R9: csum_valid rises on the read that opens the pair for identifier bit 63. From then until the next wake, csum shows the final checksum and does not change.
- R10: When wake and rd are both high in one cycle, wake takes effect and the read is ignored, so rd_data keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake | input | 1 | Enter isolation and restart the stream |
| ident | input | 64 | Card identifier, sent LSB first |
| rd | input | 1 | One-cycle read strobe of the isolation register |
| rd_data | output | 8 | Read value, valid the cycle after rd |
| iso_active | output | 1 | Isolation phase in progress |
| iso_done | output | 1 | One-cycle pulse when the last pair completes |
| csum | output | 8 | Running / final checksum register |
| csum_valid | output | 1 | Checksum holds its final value |

## Verification
The checker follows the pairing of reads on its own. On every cycle it confirms four things:
- Each read that closes a pair doubles the previous value, and rd_data only ever holds 0x00, 0x55 or 0xAA.
- A read outside isolation yields zero.
- Isolation ends only through the done pulse.
- The checksum holds still once it is marked valid.

Only the bench's scenarios can show that the right bit appears at the right position and that the checksum arithmetic is correct. The bench reruns whole streams for a walking-one identifier at every position and for several dense patterns, compares every read against a reference computed in the bench, and covers a wake in mid-stream and a wake that collides with a read.

// File: rtl/iso_id_shifter.sv
module iso_id_shifter #(
  parameter int ID_W = 64,
  parameter int CK_W = 8,
  parameter logic [CK_W-1:0] SEED = 8'h6A,
  parameter logic [7:0] ONE_PAT = 8'h55
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wake,
  input  logic [ID_W-1:0] ident,
  input  logic            rd,
  output logic [7:0]      rd_data,
  output logic            iso_active,
  output logic            iso_done,
  output logic [CK_W-1:0] csum,
  output logic            csum_valid
);
  localparam int TOT = ID_W + CK_W;
  localparam int PW  = $clog2(TOT + 1);
  localparam int IW  = $clog2(ID_W);
  localparam int CW  = $clog2(CK_W);
  localparam logic [PW-1:0] LAST_POS = PW'(TOT - 1);
  localparam logic [PW-1:0] ID_END   = PW'(ID_W);
  localparam logic [PW-1:0] ID_LAST  = PW'(ID_W - 1);

  logic [PW-1:0]   pos;
  logic            pair;
  logic [CK_W-1:0] lfsr;

  wire            in_id  = pos < ID_END;
  wire [PW-1:0]   ck_off = pos - ID_END;
  wire            cur_bit = in_id ? ident[pos[IW-1:0]] : lfsr[ck_off[CW-1:0]];
  wire            fb      = lfsr[0] ^ lfsr[1] ^ cur_bit;
  wire [PW-1:0]   pos_nxt = (pos == LAST_POS) ? '0 : pos + 1'b1;
  wire            rd_iso  = rd && iso_active;

  assign csum = lfsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '0;
      pair       <= 1'b0;
      lfsr       <= SEED;
      rd_data    <= 8'h00;
      iso_active <= 1'b0;
      iso_done   <= 1'b0;
      csum_valid <= 1'b0;
    end else begin
      iso_done <= 1'b0;
      if (wake) begin
        pos        <= '0;
        pair       <= 1'b0;
        lfsr       <= SEED;
        iso_active <= 1'b1;
        csum_valid <= 1'b0;
      end else if (rd && !iso_active) begin
        rd_data <= 8'h00;
      end else if (rd_iso && !pair) begin
        rd_data <= cur_bit ? ONE_PAT : 8'h00;
        if (in_id) lfsr <= {fb, lfsr[CK_W-1:1]};
        if (pos == ID_LAST) csum_valid <= 1'b1;
        pos  <= pos_nxt;
        pair <= 1'b1;
      end else if (rd_iso) begin
        rd_data <= {rd_data[6:0], 1'b0};
        pair    <= 1'b0;
        if (pos == '0) begin
          iso_active <= 1'b0;
          iso_done   <= 1'b1;
        end
      end
    end
  end
endmodule

module iso_id_shifter_chk #(
  parameter int CK_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wake,
  input logic            rd,
  input logic [7:0]      rd_data,
  input logic            iso_active,
  input logic            iso_done,
  input logic [CK_W-1:0] csum,
  input logic            csum_valid
);
  logic seen_pair;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_pair <= 1'b0;
    else if (wake) seen_pair <= 1'b0;
    else if (rd && iso_active) seen_pair <= !seen_pair;
  end

  // R4
  pair_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && iso_active && !wake && seen_pair |=> rd_data == {$past(rd_data[6:0]), 1'b0});

  // R3
  data_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == 8'h00 || rd_data == 8'h55 || rd_data == 8'hAA);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !iso_active && !wake |=> rd_data == 8'h00 && !iso_active);

  // R7
  exit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_active) |-> iso_done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iso_done |=> !iso_done);

  // R9
  csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csum_valid && !wake |=> $stable(csum) && csum_valid);

  // R10
  wake_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake && rd |=> $stable(rd_data) && iso_active);
endmodule

bind iso_id_shifter iso_id_shifter_chk #(.CK_W(CK_W)) chk (
  .clk(clk), .rst_n(rst_n), .wake(wake), .rd(rd), .rd_data(rd_data),
  .iso_active(iso_active), .iso_done(iso_done), .csum(csum), .csum_valid(csum_valid)
);

// File: tb/iso_id_shifter_test.sv
`timescale 1ns/1ps
module iso_id_shifter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake = 1'b0;
  logic rd = 1'b0;
  logic [63:0] ident = '0;
  logic [7:0] rd_data;
  logic iso_active, iso_done, csum_valid;
  logic [7:0] csum;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  iso_id_shifter uut (
    .clk(clk), .rst_n(rst_n), .wake(wake), .ident(ident), .rd(rd),
    .rd_data(rd_data), .iso_active(iso_active), .iso_done(iso_done),
    .csum(csum), .csum_valid(csum_valid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_csum(input logic [63:0] id);
    logic [7:0] c = 8'h6A;
    for (int i = 0; i < 64; i++) c = {c[0] ^ c[1] ^ id[i], c[7:1]};
    return c;
  endfunction

  task automatic do_read();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic do_wake();
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
    check(iso_active && !csum_valid, "R2", {iso_active, csum_valid}, 2'b10);
  endtask

  // full stream, every read compared
  task automatic run_stream(input logic [63:0] id);
    logic [7:0] ec = ref_csum(id);
    logic b;
    ident = id;
    do_wake();
    for (int p = 0; p < 72; p++) begin
      b = (p < 64) ? id[p] : ec[p-64];
      do_read();
      check(rd_data == (b ? 8'h55 : 8'h00), (p < 64) ? "R3 R5" : "R5 R6",
            rd_data, b ? 8'h55 : 8'h00);
      if (p == 63) check(csum_valid && csum == ec, "R9 R6", {csum_valid, csum}, {1'b1, ec});
      do_read();
      check(rd_data == (b ? 8'hAA : 8'h00), "R4", rd_data, b ? 8'hAA : 8'h00);
      if (p == 71)
        check(!iso_active && iso_done, "R7", {iso_active, iso_done}, 2'b01);
      else
        check(iso_active && !iso_done, "R7", {iso_active, iso_done}, 2'b10);
    end
    @(negedge clk);
    check(!iso_done && csum_valid && csum == ec, "R7 R9", {iso_done, csum_valid, csum}, {2'b01, ec});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!iso_active && !iso_done && !csum_valid && rd_data == 8'h00, "R1",
          {iso_active, iso_done, csum_valid, rd_data}, 0);
    rst_n = 1'b1;
    ident = 64'hFFFF_FFFF_FFFF_FFFF;
    // R8 before any wake
    do_read();
    check(rd_data == 8'h00 && !iso_active, "R8", {iso_active, rd_data}, 0);

    run_stream('0);
    run_stream('1);
    run_stream(64'h8000_0000_0000_0001);
    run_stream(64'hAAAA_5555_AAAA_5555);
    run_stream(64'h0123_4567_89AB_CDEF);
    run_stream(64'h4A8C_0019_10EC_8019);
    for (int k = 0; k < 64; k++) run_stream(64'd1 << k);

    // R8 after completion: read stays zero, stream not restarted
    do_read();
    check(rd_data == 8'h00 && !iso_active && !iso_done, "R8", {iso_active, iso_done, rd_data}, 0);

    // R2 mid-stream wake restarts at bit 0
    ident = 64'h0000_0000_0000_0FFE;
    do_wake();
    for (int p = 0; p < 20; p++) begin do_read(); do_read(); end
    check(csum != 8'h6A, "R2", csum, 8'h6A);
    do_wake();
    check(csum == 8'h6A, "R2", csum, 8'h6A);
    do_read();
    check(rd_data == 8'h00, "R2 R5", rd_data, 8'h00);
    do_read();
    do_read();
    check(rd_data == 8'h55, "R2 R5", rd_data, 8'h55);

    // R10 wake colliding with a read: read ignored, then restart at bit 0
    @(negedge clk) begin wake = 1'b1; rd = 1'b1; end
    @(negedge clk) begin wake = 1'b0; rd = 1'b0; end
    check(rd_data == 8'h55 && iso_active, "R10", rd_data, 8'h55);
    do_read();
    check(rd_data == 8'h00, "R10", rd_data, 8'h00);
    do_read();
    check(rd_data == 8'h00, "R10 R4", rd_data, 8'h00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule